// File: doc/BRIEF.md
# Raster Timing and Window Generator

This block produces the raster timing for a display pipeline. A horizontal pixel counter and a vertical line counter run freely while the generator is started. Software programs every boundary as an inclusive corner coordinate: the last pixel of the frame, the two corners of the visible display window, and the two corners of each of three overlay channel windows. The block compares the counters against these corners on every pixel clock. It reports whether the current pixel is inside the display window and, for each enabled channel, whether it is inside that channel's window.

The same counters drive two context-load strobes, each one pulse per frame on a programmed line. They also drive four line-match interrupt sources. These have sticky status bits, a mask and a write-one-to-clear port. The corner registers are staged in shadow copies, so a new geometry takes effect only at a frame boundary and never partway through a frame. An 8-bit default foreground alpha value is held in the control register and passed on to the blender downstream.

Software reaches the block through a single-cycle register write port and a combinational read port. Byte offsets are 8 bits wide. Each corner word holds X in bits 12:0 and Y in bits 28:16.

Top module: `raster_window_gen`

## Requirements
- R1: After reset, the control word at offset 0x00 reads 0xFF000000 and `fg_alpha` is 255. Both counters are 0, and `disp_active`, `ch_active`, both strobes and `line_irq` are low.
- R2: While control bit 8 (run) is set, `h_pos` steps by one each clock from 0 up to the frame corner X and then returns to 0. `v_pos` steps once per horizontal wrap, from 0 up to the frame corner Y, and then returns to 0. The frame corner is at offset 0x04.
- R3: When run is cleared, both counters are 0 from the second clock after the write and stay there.
- R4: The display window corners are at offset 0x08 (upper-left) and 0x0C (lower-right). `disp_active` is high exactly when upper-left X < `h_pos` <= lower-right X and upper-left Y < `v_pos` <= lower-right Y.
- R5: Channel n (n = 1..3) has its upper-left corner at 0x10+8(n-1) and its lower-right corner at 0x14+8(n-1). `ch_active[n-1]` follows the same strict-lower and inclusive-upper rule, so a channel whose two corners are both zero is never active.
- R6: Control bit 2 enables channel 1, bit 1 enables channel 2 and bit 0 enables channel 3. A disabled channel holds its `ch_active` bit low.
- R7: The word at 0x28 holds a line in bits 12:0 and another line in bits 28:16. `ctx_db_pulse` (for bits 12:0) and `ctx_sb_pulse` (for bits 28:16) are high for the single clock in which the counters are running, `h_pos` is 0 and `v_pos` equals that line.
- R8: Line-match source k (k = 0..3) takes its line from bits 28:16 of offsets 0x50, 0x54, 0x6C and 0x70 respectively. Status bit k (offset 0x5C, bits 3:0) is set when the running counters reach X = 0 on that line, and it stays set. Writing a one to bit k of offset 0x60 clears it. A set and a clear in the same clock leave the bit set.
- R9: `line_irq` is the OR over k of status bit k AND mask bit k. The mask is at offset 0x68, bits 3:0.
- R10: A write to a corner register (0x04 to 0x24) reads back at once. It affects the timing only from the clock after the counters sit on the frame corner, or from the next clock while the generator is stopped.
- R11: Control bits 31:24 drive `fg_alpha` and have no effect on the counters or the windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| h_pos | output | 13 | Horizontal pixel counter |
| v_pos | output | 13 | Vertical line counter |
| disp_active | output | 1 | Pixel is inside the display window |
| ch_active | output | 3 | Per-channel in-window flags, bit 0 is channel 1 |
| ctx_db_pulse | output | 1 | Strobe on the line set in bits 12:0 of 0x28 |
| ctx_sb_pulse | output | 1 | Strobe on the line set in bits 28:16 of 0x28 |
| line_irq | output | 1 | Masked OR of the line-match status bits |
| fg_alpha | output | 8 | Default foreground alpha for the blender |

## Verification
The bench builds the block with its default parameters: 13-bit coordinates, three channels and four line-match sources. It then programs a 20 by 12 pixel frame, so one frame lasts 240 clocks. With frames that short, many frame boundaries fit into one run. That brings into reach the deferred loading of corners at a boundary, the repeated once-per-frame setting of interrupt status, a clear that lands on the same clock as a set, and the counter wrap on both axes.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int COORD_W   = 13;
  localparam int Y_LSB     = 16;
  localparam int RUN_BIT   = 8;
  localparam int ALPHA_LSB = 24;
  localparam int ALPHA_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CORNER = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTX    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LSTAT  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_LCLR   = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_LMASK  = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_LLOW   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_LHIGH  = 8'h6C;

  localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(8'hFF) << ALPHA_LSB;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    coord_t y;
    coord_t x;
  } corner_t;

  function automatic corner_t unpack_corner(input logic [DATA_W-1:0] d);
    corner_t c;
    c.x = d[COORD_W-1:0];
    c.y = d[Y_LSB +: COORD_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_corner(input corner_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[COORD_W-1:0]    = c.x;
    r[Y_LSB +: COORD_W] = c.y;
    return r;
  endfunction

  // Corner i sits in consecutive words: frame, display UL/LR, then channel pairs.
  function automatic logic [ADDR_W-1:0] corner_addr(input int i);
    return ADDR_W'(int'(OFS_CORNER) + 4 * i);
  endfunction

  // Line-match sources occupy two pairs of words in separate regions.
  function automatic logic [ADDR_W-1:0] line_addr(input int k);
    if (k < 2) return ADDR_W'(int'(OFS_LLOW) + 4 * k);
    return ADDR_W'(int'(OFS_LHIGH) + 4 * (k - 2));
  endfunction

endpackage

// File: rtl/rwg_regs.sv
module rwg_regs
  import rwg_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int NUM_LINES   = 4,
  parameter int NUM_CORNERS = 3 + 2 * NUM_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 load_act,
  input  logic [NUM_LINES-1:0] status,
  output logic                 run,
  output logic [NUM_CH-1:0]    ch_en,
  output logic [ALPHA_W-1:0]   alpha,
  output corner_t              corner_act [NUM_CORNERS],
  output coord_t               ctx_db_line,
  output coord_t               ctx_sb_line,
  output coord_t               line_no    [NUM_LINES],
  output logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] clr
);

  // Control word
  logic              ctrl_en;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  assign ctrl_en = we && (addr == OFS_CTRL);
  assign ctrl_d  = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign run   = ctrl_q[RUN_BIT];
  assign alpha = ctrl_q[ALPHA_LSB +: ALPHA_W];

  // Channel 1 is the highest enable bit, the last channel is bit 0.
  for (genvar k = 0; k < NUM_CH; k++) begin : g_en
    assign ch_en[k] = ctrl_q[NUM_CH-1-k];
  end

  // Corner shadows and active copies
  logic [NUM_CORNERS-1:0][DATA_W-1:0] corner_rd;

  for (genvar i = 0; i < NUM_CORNERS; i++) begin : g_corner
    logic    sh_en;
    corner_t sh_q, sh_d, act_q, act_d;

    assign sh_en = we && (addr == corner_addr(i));
    assign sh_d  = unpack_corner(wdata);
    assign act_d = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (sh_en) sh_q <= sh_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        act_q <= '0;
      else if (load_act) act_q <= act_d;
    end

    assign corner_act[i] = act_q;
    assign corner_rd[i]  = (addr == corner_addr(i)) ? pack_corner(sh_q) : '0;
  end

  // Context-load trigger lines
  logic   ctx_en;
  coord_t ctx_db_q, ctx_sb_q;

  assign ctx_en = we && (addr == OFS_CTX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_db_q <= '0;
      ctx_sb_q <= '0;
    end else if (ctx_en) begin
      ctx_db_q <= wdata[COORD_W-1:0];
      ctx_sb_q <= wdata[Y_LSB +: COORD_W];
    end
  end

  assign ctx_db_line = ctx_db_q;
  assign ctx_sb_line = ctx_sb_q;

  // Line-match trigger lines
  logic [NUM_LINES-1:0][DATA_W-1:0] line_rd;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic   ln_en;
    coord_t ln_q;

    assign ln_en = we && (addr == line_addr(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ln_q <= '0;
      else if (ln_en) ln_q <= wdata[Y_LSB +: COORD_W];
    end

    assign line_no[k] = ln_q;
    assign line_rd[k] = (addr == line_addr(k)) ? (DATA_W'(ln_q) << Y_LSB) : '0;
  end

  // Mask and clear
  logic                 mask_en;
  logic [NUM_LINES-1:0] mask_q;

  assign mask_en = we && (addr == OFS_LMASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= wdata[NUM_LINES-1:0];
  end

  assign mask = mask_q;
  assign clr  = (we && (addr == OFS_LCLR)) ? wdata[NUM_LINES-1:0] : '0;

  // Read mux
  always_comb begin
    rdata = '0;
    if (addr == OFS_CTRL)  rdata = ctrl_q;
    if (addr == OFS_CTX)   rdata = DATA_W'(ctx_db_q) | (DATA_W'(ctx_sb_q) << Y_LSB);
    if (addr == OFS_LSTAT) rdata = DATA_W'(status);
    if (addr == OFS_LMASK) rdata = DATA_W'(mask_q);
    for (int i = 0; i < NUM_CORNERS; i++) rdata = rdata | corner_rd[i];
    for (int k = 0; k < NUM_LINES; k++)   rdata = rdata | line_rd[k];
  end

endmodule

// File: rtl/rwg_raster.sv
module rwg_raster
  import rwg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  corner_t frame,
  output coord_t  h,
  output coord_t  v,
  output logic    eof
);

  coord_t h_q, h_d, v_q, v_d;
  logic   h_last, v_last;

  assign h_last = (h_q == frame.x);
  assign v_last = (v_q == frame.y);

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (!run) begin
      h_d = '0;
      v_d = '0;
    end else if (h_last) begin
      h_d = '0;
      v_d = v_last ? '0 : v_q + 1'b1;
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h   = h_q;
  assign v   = v_q;
  assign eof = run && h_last && v_last;

endmodule

// File: rtl/rwg_window.sv
module rwg_window
  import rwg_pkg::*;
(
  input  coord_t  h,
  input  coord_t  v,
  input  corner_t ul,
  input  corner_t lr,
  input  logic    en,
  output logic    active
);

  logic in_x, in_y;

  // Upper-left is exclusive, lower-right inclusive.
  assign in_x   = (h > ul.x) && (h <= lr.x);
  assign in_y   = (v > ul.y) && (v <= lr.y);
  assign active = en && in_x && in_y;

endmodule

// File: rtl/rwg_line_events.sv
module rwg_line_events
  import rwg_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  coord_t               h,
  input  coord_t               v,
  input  coord_t               line_no [NUM_LINES],
  input  coord_t               ctx_db_line,
  input  coord_t               ctx_sb_line,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] status,
  output logic                 irq,
  output logic                 db_pulse,
  output logic                 sb_pulse
);

  logic                 line_start;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] status_q, status_d;

  assign line_start = run && (h == '0);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_hit
    assign hit[k] = line_start && (v == line_no[k]);
  end

  // A hit outranks a clear landing on the same clock.
  assign status_d = (status_q & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status   = status_q;
  assign irq      = |(status_q & mask);
  assign db_pulse = line_start && (v == ctx_db_line);
  assign sb_pulse = line_start && (v == ctx_sb_line);

endmodule

// File: rtl/raster_window_gen.sv
module raster_window_gen
  import rwg_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [COORD_W-1:0]   h_pos,
  output logic [COORD_W-1:0]   v_pos,
  output logic                 disp_active,
  output logic [NUM_CH-1:0]    ch_active,
  output logic                 ctx_db_pulse,
  output logic                 ctx_sb_pulse,
  output logic                 line_irq,
  output logic [ALPHA_W-1:0]   fg_alpha
);

  localparam int NUM_CORNERS = 3 + 2 * NUM_CH;
  localparam int IDX_FRAME   = 0;
  localparam int IDX_DISP_UL = 1;
  localparam int IDX_DISP_LR = 2;
  localparam int IDX_CH_BASE = 3;

  logic                 run_q;
  logic                 eof;
  logic                 load_act;
  logic [NUM_CH-1:0]    ch_en;
  corner_t              corner_act [NUM_CORNERS];
  corner_t              frame_act;
  coord_t               ctx_db_line, ctx_sb_line;
  coord_t               line_no [NUM_LINES];
  logic [NUM_LINES-1:0] line_mask, line_clr, line_status;
  coord_t               h_q, v_q;

  // Active corners follow the shadows while stopped, and at frame end otherwise.
  assign load_act  = !run_q || eof;
  assign frame_act = corner_act[IDX_FRAME];

  rwg_regs #(
    .NUM_CH      (NUM_CH),
    .NUM_LINES   (NUM_LINES),
    .NUM_CORNERS (NUM_CORNERS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .load_act    (load_act),
    .status      (line_status),
    .run         (run_q),
    .ch_en       (ch_en),
    .alpha       (fg_alpha),
    .corner_act  (corner_act),
    .ctx_db_line (ctx_db_line),
    .ctx_sb_line (ctx_sb_line),
    .line_no     (line_no),
    .mask        (line_mask),
    .clr         (line_clr)
  );

  rwg_raster u_raster (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .frame (frame_act),
    .h     (h_q),
    .v     (v_q),
    .eof   (eof)
  );

  assign h_pos = h_q;
  assign v_pos = v_q;

  rwg_window u_disp_win (
    .h      (h_q),
    .v      (v_q),
    .ul     (corner_act[IDX_DISP_UL]),
    .lr     (corner_act[IDX_DISP_LR]),
    .en     (1'b1),
    .active (disp_active)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    rwg_window u_ch_win (
      .h      (h_q),
      .v      (v_q),
      .ul     (corner_act[IDX_CH_BASE + 2*k]),
      .lr     (corner_act[IDX_CH_BASE + 2*k + 1]),
      .en     (ch_en[k]),
      .active (ch_active[k])
    );
  end

  rwg_line_events #(
    .NUM_LINES (NUM_LINES)
  ) u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_q),
    .h           (h_q),
    .v           (v_q),
    .line_no     (line_no),
    .ctx_db_line (ctx_db_line),
    .ctx_sb_line (ctx_sb_line),
    .mask        (line_mask),
    .clr         (line_clr),
    .status      (line_status),
    .irq         (line_irq),
    .db_pulse    (ctx_db_pulse),
    .sb_pulse    (ctx_sb_pulse)
  );

endmodule

// File: rtl/rwg_checker.sv
module rwg_checker
  import rwg_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_LINES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input coord_t               h,
  input coord_t               v,
  input corner_t              frame,
  input logic                 eof,
  input logic [NUM_CH-1:0]    ch_en,
  input logic [NUM_CH-1:0]    ch_active,
  input logic                 ctx_db,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] clr,
  input logic                 irq
);

  a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (h != frame.x)) |=> (h == COORD_W'($past(h) + 1'b1)));

  a_r2_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (h == frame.x)) |=> (h == '0));

  a_r3_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((h == '0) && (v == '0)));

  a_r7_db_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_db && (frame.x != '0)) |=> !ctx_db);

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((status & $past(status)) == $past(status)));

  a_r9_no_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  a_r10_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !eof) |=> $stable(frame));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch_chk
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[k] |-> !ch_active[k]);
  end

endmodule

bind raster_window_gen rwg_checker #(
  .NUM_CH    (NUM_CH),
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_q),
  .h         (h_q),
  .v         (v_q),
  .frame     (frame_act),
  .eof       (eof),
  .ch_en     (ch_en),
  .ch_active (ch_active),
  .ctx_db    (ctx_db_pulse),
  .status    (line_status),
  .mask      (line_mask),
  .clr       (line_clr),
  .irq       (line_irq)
);

// File: tb/raster_window_gen_tb.sv
`timescale 1ns/1ps
module raster_window_gen_tb;

  localparam int NCH = 3;
  localparam int NL  = 4;
  localparam int NCR = 3 + 2 * NCH;
  localparam int FX  = 19;
  localparam int FY  = 11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [12:0] h_pos, v_pos;
  logic        disp_active;
  logic [2:0]  ch_active;
  logic        ctx_db_pulse, ctx_sb_pulse, line_irq;
  logic [7:0]  fg_alpha;

  always #2 clk = ~clk;

  raster_window_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .h_pos        (h_pos),
    .v_pos        (v_pos),
    .disp_active  (disp_active),
    .ch_active    (ch_active),
    .ctx_db_pulse (ctx_db_pulse),
    .ctx_sb_pulse (ctx_sb_pulse),
    .line_irq     (line_irq),
    .fg_alpha     (fg_alpha)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Model state, built from the requirements
  int          m_h, m_v;
  logic [31:0] m_ctrl;
  int          sx[NCR], sy[NCR], ax[NCR], ay[NCR];
  int          m_db, m_sb;
  int          m_line[NL];
  logic [3:0]  m_mask, m_status;

  function automatic logic [31:0] pk(input int x, input int y);
    return (32'(y) << 16) | 32'(x);
  endfunction

  function automatic logic [7:0] lofs(input int k);
    case (k)
      0: return 8'h50;
      1: return 8'h54;
      2: return 8'h6C;
      default: return 8'h70;
    endcase
  endfunction

  function automatic bit inwin(input int h, input int v, input int i_ul, input int i_lr);
    return (h > ax[i_ul]) && (h <= ax[i_lr]) && (v > ay[i_ul]) && (v <= ay[i_lr]);
  endfunction

  task automatic chk(input string req, input string what, input longint actual, input longint expected);
    n_chk++;
    if (actual != expected) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic model_reset();
    m_h = 0; m_v = 0; m_ctrl = 32'hFF00_0000;
    for (int i = 0; i < NCR; i++) begin sx[i] = 0; sy[i] = 0; ax[i] = 0; ay[i] = 0; end
    m_db = 0; m_sb = 0;
    for (int k = 0; k < NL; k++) m_line[k] = 0;
    m_mask = '0; m_status = '0;
  endtask

  // Advance the model across one rising edge with the inputs now driven.
  task automatic model_edge();
    bit         run, eof;
    logic [3:0] set, clr;
    int         nh, nv;
    run = m_ctrl[8];
    eof = run && (m_h == ax[0]) && (m_v == ay[0]);
    set = '0;
    for (int k = 0; k < NL; k++)
      if (run && m_h == 0 && m_v == m_line[k]) set[k] = 1'b1;
    clr = (reg_we && reg_addr == 8'h60) ? reg_wdata[3:0] : 4'h0;
    if (!run) begin nh = 0; nv = 0; end
    else if (m_h == ax[0]) begin nh = 0; nv = (m_v == ay[0]) ? 0 : m_v + 1; end
    else begin nh = m_h + 1; nv = m_v; end
    if (!run || eof)
      for (int i = 0; i < NCR; i++) begin ax[i] = sx[i]; ay[i] = sy[i]; end
    m_status = (m_status & ~clr) | set;
    m_h = nh; m_v = nv;
    if (reg_we) begin
      if (reg_addr == 8'h00) m_ctrl = reg_wdata;
      for (int i = 0; i < NCR; i++)
        if (reg_addr == 8'(4 + 4*i)) begin sx[i] = int'(reg_wdata[12:0]); sy[i] = int'(reg_wdata[28:16]); end
      if (reg_addr == 8'h28) begin m_db = int'(reg_wdata[12:0]); m_sb = int'(reg_wdata[28:16]); end
      for (int k = 0; k < NL; k++)
        if (reg_addr == lofs(k)) m_line[k] = int'(reg_wdata[28:16]);
      if (reg_addr == 8'h68) m_mask = reg_wdata[3:0];
    end
  endtask

  task automatic check_outputs();
    bit run;
    run = m_ctrl[8];
    chk("R2", "h_pos", h_pos, m_h);
    chk("R2", "v_pos", v_pos, m_v);
    chk("R4", "disp_active", disp_active, inwin(m_h, m_v, 1, 2));
    for (int k = 0; k < NCH; k++) begin
      bit en;
      en = m_ctrl[2-k];
      chk(en ? "R5" : "R6", $sformatf("ch_active[%0d]", k), ch_active[k],
          en && inwin(m_h, m_v, 3 + 2*k, 4 + 2*k));
    end
    chk("R7", "ctx_db_pulse", ctx_db_pulse, run && m_h == 0 && m_v == m_db);
    chk("R7", "ctx_sb_pulse", ctx_sb_pulse, run && m_h == 0 && m_v == m_sb);
    chk("R9", "line_irq", line_irq, |(m_status & m_mask));
    chk("R11", "fg_alpha", fg_alpha, m_ctrl[31:24]);
  endtask

  task automatic cyc();
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_pos(input int x, input int y);
    while (!(m_h == x && m_v == y)) cyc();
  endtask

  // Scenarios

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "h_pos", h_pos, 0);
    chk("R1", "v_pos", v_pos, 0);
    chk("R1", "disp_active", disp_active, 0);
    chk("R1", "ch_active", ch_active, 0);
    chk("R1", "strobes", {ctx_db_pulse, ctx_sb_pulse}, 0);
    chk("R1", "line_irq", line_irq, 0);
    chk("R1", "fg_alpha", fg_alpha, 255);
    rd(8'h00, d);
    chk("R1", "control readback", d, 32'hFF00_0000);
  endtask

  task automatic t_counters();
    wr(8'h04, pk(FX, FY));
    wr(8'h00, 32'hFF00_0100);
    idle(3 * (FX + 1) * (FY + 1));
    wait_pos(FX, FY);
    cyc();
    chk("R2", "wrap h", h_pos, 0);
    chk("R2", "wrap v", v_pos, 0);
  endtask

  task automatic t_windows();
    int c_disp, c1, c2, c3;
    logic [31:0] d;
    wr(8'h08, pk(3, 2));
    wr(8'h0C, pk(15, 9));
    wr(8'h10, pk(5, 3));
    wr(8'h14, pk(8, 6));
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h20, pk(0, 0));
    wr(8'h24, pk(FX, FY));
    wr(8'h00, 32'hFF00_0107);
    wait_pos(0, 0);
    wait_pos(0, 0);
    c_disp = 0; c1 = 0; c2 = 0; c3 = 0;
    for (int i = 0; i < (FX + 1) * (FY + 1); i++) begin
      c_disp += int'(disp_active);
      c1 += int'(ch_active[0]);
      c2 += int'(ch_active[1]);
      c3 += int'(ch_active[2]);
      cyc();
    end
    chk("R4", "display pixels per frame", c_disp, 84);
    chk("R5", "channel 1 pixels per frame", c1, 9);
    chk("R5", "all-zero channel 2 pixels", c2, 0);
    chk("R5", "channel 3 pixels per frame", c3, 209);
    wr(8'h00, 32'hFF00_0104);
    c3 = 0;
    for (int i = 0; i < (FX + 1) * (FY + 1); i++) begin
      c3 += int'(ch_active[2]);
      cyc();
    end
    chk("R6", "disabled channel 3 pixels", c3, 0);
    rd(8'h24, d);
    chk("R6", "channel 3 corner kept", d, pk(FX, FY));
  endtask

  task automatic t_ctx();
    int n_db, n_sb, pos_db;
    wr(8'h28, pk(7, 4));
    wait_pos(0, 0);
    n_db = 0; n_sb = 0; pos_db = -1;
    for (int i = 0; i < (FX + 1) * (FY + 1); i++) begin
      if (ctx_db_pulse) begin n_db++; pos_db = m_v * 100 + m_h; end
      n_sb += int'(ctx_sb_pulse);
      cyc();
    end
    chk("R7", "db pulses per frame", n_db, 1);
    chk("R7", "sb pulses per frame", n_sb, 1);
    chk("R7", "db pulse position", pos_db, 700);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(lofs(0), pk(0, 2));
    wr(lofs(1), pk(0, 5));
    wr(lofs(2), pk(0, 8));
    wr(lofs(3), pk(0, 10));
    wr(8'h68, 32'h5);
    wait_pos(5, 0);
    wr(8'h60, 32'hF);
    rd(8'h5C, d);
    chk("R8", "status after clear all", d, 0);
    chk("R9", "irq after clear all", line_irq, 0);
    wait_pos(5, 0);
    rd(8'h5C, d);
    chk("R8", "status after a frame", d, 32'hF);
    chk("R9", "irq with status", line_irq, 1);
    wr(8'h60, 32'h5);
    rd(8'h5C, d);
    chk("R8", "status after partial clear", d, 32'hA);
    chk("R9", "irq with only masked-off bits", line_irq, 0);
    wait_pos(0, 2);
    wr(8'h60, 32'h1);
    rd(8'h5C, d);
    chk("R8", "set beats clear", d[0], 1);
    chk("R9", "irq after set", line_irq, 1);
    wr(8'h68, 32'h0);
    chk("R9", "irq with mask zero", line_irq, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wait_pos(0, 4);
    wr(8'h0C, pk(17, 10));
    rd(8'h0C, d);
    chk("R10", "corner readback", d, pk(17, 10));
    wait_pos(16, 5);
    chk("R10", "old window kept mid-frame", disp_active, 0);
    wait_pos(0, 0);
    wait_pos(16, 5);
    chk("R10", "new window after frame end", disp_active, 1);
  endtask

  task automatic t_alpha_stop();
    wr(8'h00, 32'h1200_0105);
    chk("R11", "alpha output", fg_alpha, 8'h12);
    idle(30);
    wr(8'h00, 32'h1200_0000);
    cyc();
    chk("R3", "h after stop", h_pos, 0);
    chk("R3", "v after stop", v_pos, 0);
    idle(25);
    chk("R3", "h held", h_pos, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counters();
    t_windows();
    t_ctx();
    t_irq();
    t_shadow();
    t_alpha_stop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule